// File: doc/BRIEF.md
# Key-Protected Flash Program/Erase Controller

This block is the command side of an on-chip flash. Software reaches it through a small register bus (a key register, a control register, a status register and an address register) and through halfword stores into the flash address window. The controller does not hold the array itself. It decides when an operation may start, times it, and issues one commit command per finished operation to the array model outside. That model applies the erase or program result at the commit edge.

The control register is guarded by a key lock built as a state machine with four states. `LK_SHUT` is the reset state. A key write of 0x45670123 moves it to `LK_HALF`. In `LK_HALF`, a key write of 0xCDEF89AB moves it to `LK_OPEN`. Any other key write in `LK_SHUT` or `LK_HALF` moves it to `LK_JAMMED`, and only reset leaves that state. In `LK_OPEN`, a control write with the lock bit set returns it to `LK_SHUT`, and key writes are ignored. The lock reads 1 in every state except `LK_OPEN`.

A second state machine sequences the operations. From `SQ_IDLE` it goes to `SQ_ERASE` on an accepted erase start, or to `SQ_PROG` on an accepted flash-window store. It stays there for a parameterised number of cycles and, in the last cycle, pulses the commit output and returns to `SQ_IDLE`.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset the control register (offset 1) reads lock bit 3 = 1 with program bit 0, erase bit 1 and start bit 2 all 0. The status register (offset 2) reads busy bit 0 = 0 and done bit 1 = 0.
- R2: Two writes to the key register (offset 0), 0x45670123 and then 0xCDEF89AB, clear the lock bit.
- R3: A key write that breaks the sequence keeps the lock set until reset, even if a correct key pair follows. A broken sequence is a wrong first value, a wrong second value, or the keys in the wrong order.
- R4: While locked, control writes leave the program and erase bits unchanged and start nothing. A control write with bit 3 = 0 never clears the lock.
- R5: Writing the control register with bit 3 = 1 while unlocked sets the lock again.
- R6: While unlocked and idle, a control write with erase bit 1 and start bit 2 both set erases the page selected by the address register (a halfword index; the page is index / PAGE_HW). Busy stays high for exactly ERASE_CYCLES cycles, and afterwards every halfword of that page reads 0xFFFF.
- R7: While unlocked, idle and with the program bit set, a halfword store into the flash window starts a program. Busy stays high for exactly PROG_CYCLES cycles, and the halfword becomes the old contents ANDed with the data.
- R8: Busy falls and done rises in the same cycle. Writing the status register with bit 1 = 1 clears done, and writing it with bit 1 = 0 leaves done unchanged.
- R9: A start write or a flash-window store that arrives while busy is ignored. It neither extends nor restarts the running operation.
- R10: The program and erase bits keep their values after an operation ends.
- R11: A flash-window store has no effect when the program bit is clear or the controller is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 key, 1 control, 2 status, 3 address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| fw_wr_en | input | 1 | Halfword store into the flash window |
| fw_addr | input | ADDR_W | Halfword index of the store |
| fw_wdata | input | 16 | Store data |
| fl_commit | output | 1 | One-cycle command to the array: apply the result |
| fl_erase | output | 1 | Commit is a page erase (1) or a halfword program (0) |
| fl_page | output | PAGE_W | Page to erase |
| fl_haddr | output | ADDR_W | Halfword to program |
| fl_data | output | 16 | Data to AND into that halfword |

## Verification
The bench attacks the key sequence from several angles: swapped keys, a repeated first key, a near-miss first key, and a correct pair sent after a broken one. A lock that merely restarted its sequence on a bad key would open in that last case. Busy length is checked cycle by cycle, so an off-by-one counter shows up as busy ending one cycle early or late. Starts and stores issued mid-operation are checked against the original finish cycle and against untouched memory, which exposes a sequencer that restarts or queues them. Repeated programs of the same halfword check the AND rule, which a design that simply overwrote the halfword would fail.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

    typedef enum logic [1:0] {
        LK_SHUT,
        LK_HALF,
        LK_OPEN,
        LK_JAMMED
    } lock_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ERASE,
        SQ_PROG
    } seq_state_e;

    localparam logic [1:0] RA_KEY  = 2'd0;
    localparam logic [1:0] RA_CTRL = 2'd1;
    localparam logic [1:0] RA_STAT = 2'd2;
    localparam logic [1:0] RA_ADDR = 2'd3;

    localparam logic [31:0] KEY_FIRST  = 32'h4567_0123;
    localparam logic [31:0] KEY_SECOND = 32'hCDEF_89AB;

    localparam int CB_PROG  = 0;
    localparam int CB_ERASE = 1;
    localparam int CB_START = 2;
    localparam int CB_LOCK  = 3;

    localparam int SB_BUSY = 0;
    localparam int SB_DONE = 1;

endpackage

// File: rtl/flash_key_guard.sv
module flash_key_guard
    import flash_pe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic [31:0] key_val,
    input  logic        relock_req,
    output logic        locked
);

    lock_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LK_SHUT;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LK_SHUT: begin
                if (key_wr) st_d = (key_val == KEY_FIRST) ? LK_HALF : LK_JAMMED;
            end
            LK_HALF: begin
                if (key_wr) st_d = (key_val == KEY_SECOND) ? LK_OPEN : LK_JAMMED;
            end
            LK_OPEN: begin
                if (relock_req) st_d = LK_SHUT;
            end
            LK_JAMMED: begin
                st_d = LK_JAMMED;
            end
            default: st_d = LK_JAMMED;
        endcase
    end

    always_comb begin
        locked = (st_q != LK_OPEN);
    end

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
    import flash_pe_pkg::*;
#(
    parameter int ERASE_CYCLES = 20,
    parameter int PROG_CYCLES  = 5,
    parameter int ADDR_W       = 7,
    parameter int PAGE_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_go,
    input  logic              prog_go,
    input  logic [PAGE_W-1:0] go_page,
    input  logic [ADDR_W-1:0] go_haddr,
    input  logic [15:0]       go_data,
    output logic              busy,
    output logic              commit,
    output logic              commit_erase,
    output logic [PAGE_W-1:0] commit_page,
    output logic [ADDR_W-1:0] commit_haddr,
    output logic [15:0]       commit_data
);

    localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYCLES - 1);
    localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYCLES - 1);

    seq_state_e        st_q, st_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [PAGE_W-1:0] page_q;
    logic [ADDR_W-1:0] haddr_q;
    logic [15:0]       data_q;
    logic              last;

    always_comb begin
        unique case (st_q)
            SQ_ERASE: last = (cnt_q == ERASE_LAST);
            SQ_PROG:  last = (cnt_q == PROG_LAST);
            default:  last = 1'b0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_IDLE: begin
                if (erase_go)     st_d = SQ_ERASE;
                else if (prog_go) st_d = SQ_PROG;
            end
            SQ_ERASE: if (last) st_d = SQ_IDLE;
            SQ_PROG:  if (last) st_d = SQ_IDLE;
            default:  st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= SQ_IDLE;
            cnt_q   <= '0;
            page_q  <= '0;
            haddr_q <= '0;
            data_q  <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == SQ_IDLE) begin
                cnt_q <= '0;
                if (erase_go) begin
                    page_q <= go_page;
                end else if (prog_go) begin
                    haddr_q <= go_haddr;
                    data_q  <= go_data;
                end
            end else if (last) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        busy         = (st_q != SQ_IDLE);
        commit       = last;
        commit_erase = (st_q == SQ_ERASE);
        commit_page  = page_q;
        commit_haddr = haddr_q;
        commit_data  = data_q;
    end

endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
    import flash_pe_pkg::*;
#(
    parameter int ERASE_CYCLES = 20,
    parameter int PROG_CYCLES  = 5,
    parameter int PAGE_HW      = 16,
    parameter int NUM_PAGES    = 8,
    localparam int ADDR_W      = $clog2(PAGE_HW * NUM_PAGES),
    localparam int PG_LOG2     = $clog2(PAGE_HW),
    localparam int PAGE_W      = ADDR_W - PG_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              fw_wr_en,
    input  logic [ADDR_W-1:0] fw_addr,
    input  logic [15:0]       fw_wdata,
    output logic              fl_commit,
    output logic              fl_erase,
    output logic [PAGE_W-1:0] fl_page,
    output logic [ADDR_W-1:0] fl_haddr,
    output logic [15:0]       fl_data
);

    logic              locked;
    logic              busy;
    logic              prog_q, erase_q, done_q;
    logic [ADDR_W-1:0] addr_q;
    logic              key_wr, ctrl_wr, stat_wr, addr_wr;
    logic              erase_go, prog_go;

    always_comb begin
        key_wr   = reg_wr_en && (reg_addr == RA_KEY);
        ctrl_wr  = reg_wr_en && (reg_addr == RA_CTRL);
        stat_wr  = reg_wr_en && (reg_addr == RA_STAT);
        addr_wr  = reg_wr_en && (reg_addr == RA_ADDR);
        erase_go = ctrl_wr && !locked && !busy
                   && reg_wdata[CB_START] && reg_wdata[CB_ERASE];
        prog_go  = fw_wr_en && prog_q && !locked && !busy;
    end

    flash_key_guard u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_wr     (key_wr),
        .key_val    (reg_wdata),
        .relock_req (ctrl_wr && reg_wdata[CB_LOCK]),
        .locked     (locked)
    );

    flash_op_seq #(
        .ERASE_CYCLES (ERASE_CYCLES),
        .PROG_CYCLES  (PROG_CYCLES),
        .ADDR_W       (ADDR_W),
        .PAGE_W       (PAGE_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .erase_go     (erase_go),
        .prog_go      (prog_go),
        .go_page      (addr_q[ADDR_W-1:PG_LOG2]),
        .go_haddr     (fw_addr),
        .go_data      (fw_wdata),
        .busy         (busy),
        .commit       (fl_commit),
        .commit_erase (fl_erase),
        .commit_page  (fl_page),
        .commit_haddr (fl_haddr),
        .commit_data  (fl_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_q  <= 1'b0;
            erase_q <= 1'b0;
            done_q  <= 1'b0;
            addr_q  <= '0;
        end else begin
            if (ctrl_wr && !locked) begin
                prog_q  <= reg_wdata[CB_PROG];
                erase_q <= reg_wdata[CB_ERASE];
            end
            if (addr_wr) addr_q <= reg_wdata[ADDR_W-1:0];
            if (fl_commit)                        done_q <= 1'b1;
            else if (stat_wr && reg_wdata[SB_DONE]) done_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_KEY:  reg_rdata = '0;
            RA_CTRL: begin
                reg_rdata[CB_PROG]  = prog_q;
                reg_rdata[CB_ERASE] = erase_q;
                reg_rdata[CB_LOCK]  = locked;
            end
            RA_STAT: begin
                reg_rdata[SB_BUSY] = busy;
                reg_rdata[SB_DONE] = done_q;
            end
            RA_ADDR: reg_rdata[ADDR_W-1:0] = addr_q;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/flash_pe_chk.sv
module flash_pe_chk
    import flash_pe_pkg::*;
#(
    parameter int ERASE_CYCLES = 20,
    parameter int PROG_CYCLES  = 5
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic [1:0]  reg_addr,
    input logic        locked,
    input logic        busy,
    input logic        done_q,
    input logic        prog_q,
    input logic        fl_commit,
    input logic        fl_erase
);

    logic [31:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= '0;
    end

    // R4
    lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !(reg_wr_en && reg_addr == RA_KEY)) |=> locked);

    // R8
    done_with_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_commit |=> (!busy && done_q));

    // R6 R7
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_commit |-> (busy_run == (fl_erase ? ERASE_CYCLES - 1 : PROG_CYCLES - 1)));

    // R9
    commit_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_commit |-> busy);

    // R10
    prog_bit_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_addr == RA_CTRL) |=> $stable(prog_q));

endmodule

bind flash_pe_ctrl flash_pe_chk #(
    .ERASE_CYCLES (ERASE_CYCLES),
    .PROG_CYCLES  (PROG_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .locked    (locked),
    .busy      (busy),
    .done_q    (done_q),
    .prog_q    (prog_q),
    .fl_commit (fl_commit),
    .fl_erase  (fl_erase)
);

// File: tb/test_flash_pe_ctrl.sv
module test_flash_pe_ctrl;

    localparam int ERASE_CYCLES = 20;
    localparam int PROG_CYCLES  = 5;
    localparam int PAGE_HW      = 16;
    localparam int NUM_PAGES    = 8;
    localparam int ADDR_W       = $clog2(PAGE_HW * NUM_PAGES);
    localparam int PAGE_W       = ADDR_W - $clog2(PAGE_HW);
    localparam int WORDS        = PAGE_HW * NUM_PAGES;

    localparam logic [31:0] K1 = 32'h4567_0123;
    localparam logic [31:0] K2 = 32'hCDEF_89AB;

    // key pair, expected lock bit afterwards
    localparam logic [64:0] KEY_VEC [6] = '{
        {K1, K2, 1'b0},
        {K2, K1, 1'b1},
        {K1, K1, 1'b1},
        {32'h4567_0124, K2, 1'b1},
        {K1, 32'hCDEF_89AA, 1'b1},
        {32'h0, 32'h0, 1'b1}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              reg_wr_en;
    logic [1:0]        reg_addr;
    logic [31:0]       reg_wdata;
    logic [31:0]       reg_rdata;
    logic              fw_wr_en;
    logic [ADDR_W-1:0] fw_addr;
    logic [15:0]       fw_wdata;
    logic              fl_commit, fl_erase;
    logic [PAGE_W-1:0] fl_page;
    logic [ADDR_W-1:0] fl_haddr;
    logic [15:0]       fl_data;

    logic [15:0] mem [WORDS];

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    flash_pe_ctrl #(
        .ERASE_CYCLES (ERASE_CYCLES),
        .PROG_CYCLES  (PROG_CYCLES),
        .PAGE_HW      (PAGE_HW),
        .NUM_PAGES    (NUM_PAGES)
    ) i_flash_pe_ctrl (
        .clk (clk), .rst_n (rst_n),
        .reg_wr_en (reg_wr_en), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .fw_wr_en (fw_wr_en), .fw_addr (fw_addr), .fw_wdata (fw_wdata),
        .fl_commit (fl_commit), .fl_erase (fl_erase), .fl_page (fl_page),
        .fl_haddr (fl_haddr), .fl_data (fl_data)
    );

    always @(posedge clk) begin
        if (fl_commit) begin
            if (fl_erase) begin
                for (int j = 0; j < PAGE_HW; j++)
                    mem[int'(fl_page) * PAGE_HW + j] <= 16'hFFFF;
            end else begin
                mem[fl_haddr] <= mem[fl_haddr] & fl_data;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic fw_store(input int a, input logic [15:0] d);
        @(negedge clk);
        fw_wr_en = 1'b1; fw_addr = ADDR_W'(a); fw_wdata = d;
        @(negedge clk);
        fw_wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        reg_wr_en = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
        fw_wr_en = 1'b0; fw_addr = '0; fw_wdata = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic unlock();
        reg_write(2'd0, K1);
        reg_write(2'd0, K2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        for (int i = 0; i < WORDS; i++) mem[i] = 16'(i * 16'h0101) ^ 16'h5A3C;

        do_reset();
        read_reg(2'd1, rd);
        check("R1 ctrl after reset", rd, 32'h8);
        read_reg(2'd2, rd);
        check("R1 status after reset", rd, 32'h0);

        // key table walk
        for (int v = 0; v < 6; v++) begin
            do_reset();
            reg_write(2'd0, KEY_VEC[v][64:33]);
            reg_write(2'd0, KEY_VEC[v][32:1]);
            read_reg(2'd1, rd);
            check(KEY_VEC[v][0] ? "R3 broken key keeps lock" : "R2 key pair unlocks",
                  rd[3], {31'd0, KEY_VEC[v][0]});
        end

        // R3: correct pair after a broken one stays locked
        do_reset();
        reg_write(2'd0, 32'h1234_5678);
        unlock();
        read_reg(2'd1, rd);
        check("R3 jammed until reset", rd[3], 32'd1);
        reg_write(2'd1, 32'h6);
        read_reg(2'd2, rd);
        check("R3 R4 no erase when jammed", rd, 32'h0);

        // R4: locked ctrl writes ignored
        do_reset();
        reg_write(2'd1, 32'h7);
        read_reg(2'd1, rd);
        check("R4 locked ctrl write ignored", rd, 32'h8);
        read_reg(2'd2, rd);
        check("R4 locked start ignored", rd, 32'h0);

        // R5 relock
        unlock();
        reg_write(2'd1, 32'h0);
        read_reg(2'd1, rd);
        check("R2 R4 unlocked, ctrl write keeps lock clear", rd, 32'h0);
        reg_write(2'd1, 32'h8);
        read_reg(2'd1, rd);
        check("R5 relock", rd[3], 32'd1);

        // R6 erase page 2
        unlock();
        reg_write(2'd3, 32'd37);
        reg_write(2'd1, 32'h2);
        reg_write(2'd1, 32'h6);
        read_reg(2'd2, rd);
        check("R6 busy after start", rd, 32'h1);
        repeat (ERASE_CYCLES - 1) @(negedge clk);
        read_reg(2'd2, rd);
        check("R6 busy in last cycle", rd, 32'h1);
        @(negedge clk);
        read_reg(2'd2, rd);
        check("R6 R8 busy falls, done set", rd, 32'h2);
        begin
            int bad = 0;
            for (int j = 0; j < PAGE_HW; j++) if (mem[32 + j] !== 16'hFFFF) bad++;
            check("R6 page erased", bad, 0);
        end
        check("R6 neighbour page kept", {16'd0, mem[48]}, {16'd0, 16'(48 * 16'h0101) ^ 16'h5A3C});
        read_reg(2'd1, rd);
        check("R10 erase bit persists", rd, 32'h2);

        // R8 done clearing
        reg_write(2'd2, 32'h0);
        read_reg(2'd2, rd);
        check("R8 write 0 keeps done", rd, 32'h2);
        reg_write(2'd2, 32'h2);
        read_reg(2'd2, rd);
        check("R8 write 1 clears done", rd, 32'h0);

        // R7 program twice on erased halfword 40
        reg_write(2'd1, 32'h1);
        fw_store(40, 16'h1234);
        read_reg(2'd2, rd);
        check("R7 busy on store", rd, 32'h1);
        repeat (PROG_CYCLES - 1) @(negedge clk);
        read_reg(2'd2, rd);
        check("R7 busy in last cycle", rd, 32'h1);
        @(negedge clk);
        read_reg(2'd2, rd);
        check("R7 R8 program done", rd, 32'h2);
        check("R7 first program", {16'd0, mem[40]}, 32'h1234);
        fw_store(40, 16'hFF0F);
        repeat (PROG_CYCLES) @(negedge clk);
        check("R7 AND on second program", {16'd0, mem[40]}, 32'h1204);
        read_reg(2'd1, rd);
        check("R10 program bit persists", rd, 32'h1);

        // R9 start and store while busy
        reg_write(2'd3, 32'd0);
        reg_write(2'd1, 32'h7);
        repeat (3) @(negedge clk);
        reg_write(2'd1, 32'h7);
        fw_store(100, 16'h0000);
        repeat (ERASE_CYCLES - 6) @(negedge clk);
        read_reg(2'd2, rd);
        check("R9 busy not extended", rd[0], 32'd0);
        check("R9 store during busy ignored", {16'd0, mem[100]},
              {16'd0, 16'(100 * 16'h0101) ^ 16'h5A3C});

        // R11 store with program bit clear
        reg_write(2'd1, 32'h0);
        fw_store(101, 16'h0000);
        read_reg(2'd2, rd);
        check("R11 no busy, program bit clear", rd[0], 32'd0);
        repeat (PROG_CYCLES) @(negedge clk);
        check("R11 memory kept, program bit clear", {16'd0, mem[101]},
              {16'd0, 16'(101 * 16'h0101) ^ 16'h5A3C});

        // R11 store while locked with program bit set
        reg_write(2'd1, 32'h1);
        reg_write(2'd1, 32'h9);
        fw_store(102, 16'h0000);
        read_reg(2'd2, rd);
        check("R11 no busy when locked", rd[0], 32'd0);
        repeat (PROG_CYCLES) @(negedge clk);
        check("R11 memory kept when locked", {16'd0, mem[102]},
              {16'd0, 16'(102 * 16'h0101) ^ 16'h5A3C});

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule